// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This unit performs the slow arithmetic operations of a small processor core: unsigned multiply, signed multiply and unsigned divide. A single-cycle start pulse delivers the operation code, a size mode, the current value of the destination register and the value of the source register. The unit then works one bit per clock and presents one packed word that the core writes back into the destination register.

In byte mode a multiply takes eight-bit operands and produces a sixteen-bit product. A divide in byte mode takes a sixteen-bit dividend and an eight-bit divisor. In word mode every width doubles. A divide returns the remainder in the upper half of its result field and the quotient in the lower half. A zero divisor, or a quotient too large for its field, ends the operation at once and raises a flag.

Top module: `mdu_core`

## Requirements
- R1: With op_i = 2'b00 (unsigned multiply) and size_i = 0 (byte), result_o[15:0] is dst_i[7:0] times src_i[7:0] and result_o[31:16] is zero.
- R2: With op_i = 2'b00 and size_i = 1 (word), result_o is the 32-bit product of dst_i[15:0] and src_i[15:0].
- R3: With op_i = 2'b01 (signed multiply), the operands are two's complement in either size mode. The result is the exact two's-complement product: 16 bits in result_o[15:0] with the upper half zero in byte mode, or 32 bits in word mode.
- R4: With op_i = 2'b10 (unsigned divide) and size_i = 0, dst_i[15:0] is divided by src_i[7:0]. result_o is {16'b0, remainder[7:0], quotient[7:0]}.
- R5: With op_i = 2'b10 and size_i = 1, dst_i is divided by src_i[15:0]. result_o is {remainder[15:0], quotient[15:0]}.
- R6: An accepted multiply or divide that is not cut short raises done_o for exactly one cycle, starting 9 clock edges (byte) or 17 clock edges (word) after the edge that accepted it.
- R7: A divide whose divisor field is zero sets divzero_o, clears ovf_o and returns dst_i unchanged on result_o. done_o is high in the cycle after the accepting edge plus one.
- R8: A divide with a nonzero divisor whose dividend upper half (dst_i[15:8] in byte mode, dst_i[31:16] in word mode) is not below the divisor sets ovf_o and clears divzero_o. done_o follows with the same timing as R7, and the result value is undefined.
- R9: busy_o is high from the accepting edge until done_o rises. A start_i pulse while busy_o is high is ignored and does not change the result of the running operation.
- R10: A start_i pulse with op_i = 2'b11 is ignored: busy_o stays low and no done_o follows.
- R11: During reset, busy_o, done_o, divzero_o, ovf_o and result_o are all zero.
- R12: result_o, divzero_o and ovf_o hold their values from one done_o pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request, accepted only when busy_o is low |
| op_i | input | 2 | 00 unsigned multiply, 01 signed multiply, 10 unsigned divide, 11 none |
| size_i | input | 1 | 0 byte mode, 1 word mode |
| dst_i | input | 32 | Destination register value (multiplicand or dividend) |
| src_i | input | 16 | Source register value (multiplier or divisor) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Packed value for the destination register |
| divzero_o | output | 1 | Last divide had a zero divisor |
| ovf_o | output | 1 | Last divide's quotient did not fit |

## Verification
The hardest case to reach from the ports is a start pulse that lands while an operation is already running. The pulse must fall in the middle of the iteration, and it must carry different operands, so that a wrongly accepted request would corrupt the visible result. The stimulus issues one operation, waits a few cycles, and issues a conflicting one. A second case is the boundary between overflow and non-overflow, where the dividend upper half equals the divisor or sits just below it. Directed vectors pin down both sides of that boundary, and a random phase with deliberately small divisors covers the rest.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_NONE = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } mdu_st_e;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int BYTE_W = HALF_W / 2,
  localparam int CNT_W  = $clog2(HALF_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic op_ok_i,
  input  logic quick_i,
  input  logic wide_i,
  output logic accept_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);

  mdu_st_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    accept_o = 1'b0;
    step_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && op_ok_i) begin
          accept_o = 1'b1;
          if (quick_i) begin
            state_d = ST_DONE;
            cnt_d   = '0;
          end else begin
            state_d = ST_RUN;
            cnt_d   = wide_i ? CNT_W'(HALF_W) : CNT_W'(BYTE_W);
          end
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fin_o  = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE);

  // R6: the step counter never runs empty while iterating
  a_r6_run_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q != '0));

  // R6: the completion state lasts a single cycle
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R9: busy only begins from a start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R9: nothing is accepted while busy
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_o);

endmodule

// File: rtl/mdu_mul_dp.sv
module mdu_mul_dp #(
  parameter int HALF_W = 16,
  localparam int BYTE_W = HALF_W / 2,
  localparam int RES_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              signed_i,
  input  logic              wide_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [RES_W-1:0]  prod_o
);

  logic [RES_W-1:0]  acc_q, acc_d;
  logic [RES_W-1:0]  mcand_q, mcand_d;
  logic [HALF_W-1:0] mplier_q, mplier_d;
  logic              neg_q, neg_d;

  logic              a_neg, b_neg;
  logic [HALF_W-1:0] a_mag, b_mag;

  function automatic logic [HALF_W-1:0] mode_mag(
    input logic [HALF_W-1:0] v,
    input logic              wide,
    input logic              flip
  );
    logic [HALF_W-1:0] ext;
    logic [HALF_W-1:0] mask;
    ext  = wide ? v : {{(HALF_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
    mask = wide ? {HALF_W{1'b1}} : {{(HALF_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    return flip ? ((~ext + 1'b1) & mask) : ext;
  endfunction

  always_comb begin
    a_neg = signed_i && (wide_i ? a_i[HALF_W-1] : a_i[BYTE_W-1]);
    b_neg = signed_i && (wide_i ? b_i[HALF_W-1] : b_i[BYTE_W-1]);
    a_mag = mode_mag(a_i, wide_i, a_neg);
    b_mag = mode_mag(b_i, wide_i, b_neg);
  end

  always_comb begin
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    neg_d    = neg_q;
    if (load_i) begin
      acc_d    = '0;
      mcand_d  = {{HALF_W{1'b0}}, a_mag};
      mplier_d = b_mag;
      neg_d    = a_neg ^ b_neg;
    end else if (step_i) begin
      acc_d    = acc_q + (mplier_q[0] ? mcand_q : '0);
      mcand_d  = {mcand_q[RES_W-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[HALF_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      neg_q    <= 1'b0;
    end else if (load_i || step_i) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      neg_q    <= neg_d;
    end
  end

  assign prod_o = neg_q ? (~acc_q + 1'b1) : acc_q;

  // R2: the magnitude accumulator never wraps during iteration
  a_r2_acc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (acc_q >= $past(acc_q)));

  // R3: the sign correction is fixed for the whole iteration
  a_r3_sign_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(neg_q));

endmodule

// File: rtl/mdu_div_dp.sv
module mdu_div_dp #(
  parameter int HALF_W = 16,
  localparam int BYTE_W = HALF_W / 2,
  localparam int RES_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              wide_i,
  input  logic [RES_W-1:0]  dvd_i,
  input  logic [HALF_W-1:0] dvs_i,
  output logic              zero_o,
  output logic              ovf_o,
  output logic [HALF_W-1:0] quo_o,
  output logic [HALF_W-1:0] rem_o
);

  logic [HALF_W-1:0] rem_q, rem_d;
  logic [HALF_W-1:0] quo_q, quo_d;
  logic [HALF_W-1:0] dvs_q, dvs_d;
  logic              live_q, live_d;

  logic [HALF_W:0]   trial;
  logic [HALF_W:0]   diff;
  logic              fits;

  always_comb begin
    if (wide_i) begin
      zero_o = (dvs_i == '0);
      ovf_o  = !zero_o && (dvd_i[RES_W-1:HALF_W] >= dvs_i);
    end else begin
      zero_o = (dvs_i[BYTE_W-1:0] == '0);
      ovf_o  = !zero_o && (dvd_i[HALF_W-1:BYTE_W] >= dvs_i[BYTE_W-1:0]);
    end
  end

  always_comb begin
    trial = {rem_q, quo_q[HALF_W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    live_d = live_q;
    if (load_i) begin
      live_d = !(zero_o || ovf_o);
      if (wide_i) begin
        rem_d = dvd_i[RES_W-1:HALF_W];
        quo_d = dvd_i[HALF_W-1:0];
        dvs_d = dvs_i;
      end else begin
        rem_d = {{BYTE_W{1'b0}}, dvd_i[HALF_W-1:BYTE_W]};
        quo_d = {dvd_i[BYTE_W-1:0], {BYTE_W{1'b0}}};
        dvs_d = {{BYTE_W{1'b0}}, dvs_i[BYTE_W-1:0]};
      end
    end else if (step_i) begin
      rem_d = fits ? diff[HALF_W-1:0] : trial[HALF_W-1:0];
      quo_d = {quo_q[HALF_W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      live_q <= 1'b0;
    end else if (load_i || step_i) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      live_q <= live_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R5: the partial remainder stays below the divisor on a valid divide
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (rem_q < dvs_q));

  // R8: a request is never flagged as both zero divisor and overflow
  a_r8_detect_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_o && ovf_o));

endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int BYTE_W = HALF_W / 2,
  localparam int RES_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              size_i,
  input  logic [RES_W-1:0]  dst_i,
  input  logic [HALF_W-1:0] src_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic              divzero_o,
  output logic              ovf_o
);

  logic              accept, step, fin;
  logic              req_div, op_ok, quick;
  logic              dv_zero, dv_ovf;
  logic [RES_W-1:0]  prod;
  logic [HALF_W-1:0] quo, rem;

  mdu_op_e           op_q;
  logic              wide_q;
  logic [RES_W-1:0]  dst_q;
  logic              dz_q, ov_q;

  logic [RES_W-1:0]  result_q, result_d;
  logic              dzo_q, ovo_q, done_q;

  assign req_div = (op_i == OP_DIVU);
  assign op_ok   = (op_i != OP_NONE);
  assign quick   = req_div && (dv_zero || dv_ovf);

  mdu_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_ok_i  (op_ok),
    .quick_i  (quick),
    .wide_i   (size_i),
    .accept_o (accept),
    .step_o   (step),
    .fin_o    (fin),
    .busy_o   (busy_o)
  );

  mdu_mul_dp #(.HALF_W(HALF_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept && !req_div),
    .step_i   (step && (op_q != OP_DIVU)),
    .signed_i (op_i == OP_MULS),
    .wide_i   (size_i),
    .a_i      (dst_i[HALF_W-1:0]),
    .b_i      (src_i),
    .prod_o   (prod)
  );

  mdu_div_dp #(.HALF_W(HALF_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept && req_div),
    .step_i   (step && (op_q == OP_DIVU)),
    .wide_i   (size_i),
    .dvd_i    (dst_i),
    .dvs_i    (src_i),
    .zero_o   (dv_zero),
    .ovf_o    (dv_ovf),
    .quo_o    (quo),
    .rem_o    (rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_MULU;
      wide_q <= 1'b0;
      dst_q  <= '0;
      dz_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else if (accept) begin
      op_q   <= mdu_op_e'(op_i);
      wide_q <= size_i;
      dst_q  <= dst_i;
      dz_q   <= req_div && dv_zero;
      ov_q   <= req_div && dv_ovf;
    end
  end

  always_comb begin
    result_d = '0;
    if (op_q == OP_DIVU) begin
      if (dz_q) begin
        result_d = dst_q;
      end else if (ov_q) begin
        result_d = '0;
      end else if (wide_q) begin
        result_d = {rem, quo};
      end else begin
        result_d = {{HALF_W{1'b0}}, rem[BYTE_W-1:0], quo[BYTE_W-1:0]};
      end
    end else begin
      result_d = wide_q ? prod : {{HALF_W{1'b0}}, prod[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      dzo_q    <= 1'b0;
      ovo_q    <= 1'b0;
    end else if (fin) begin
      result_q <= result_d;
      dzo_q    <= dz_q;
      ovo_q    <= ov_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
    end
  end

  assign done_o    = done_q;
  assign result_o  = result_q;
  assign divzero_o = dzo_q;
  assign ovf_o     = ovo_q;

  // R12: outputs hold between completion strobes
  a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(divzero_o) && $stable(ovf_o)));

  // R6: completion is a single-cycle strobe
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: the two divide flags never appear together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(divzero_o && ovf_o));

  // R7: a zero-divisor completion hands back the original destination
  a_r7_dst_returned: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && divzero_o) |-> (result_o == dst_q));

  // R10: a no-op code never makes the unit busy
  a_r10_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (op_i == OP_NONE)) |=> !busy_o);

endmodule

// File: tb/mdu_core_tb.sv
module mdu_core_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic        size_i;
  logic [31:0] dst_i;
  logic [15:0] src_i;
  logic        busy_o, done_o, divzero_o, ovf_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mdu_core u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .size_i(size_i),
    .dst_i(dst_i), .src_i(src_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .divzero_o(divzero_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model state
  int          left;
  bit          m_done;
  logic [31:0] p_res, held_res;
  bit          p_dz, p_ov, held_dz, held_ov;
  string       p_tag, held_tag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic predict(input logic [1:0] op, input logic sz, input logic [31:0] d,
                         input logic [15:0] s, output int steps);
    longint pl;
    longint dvd, dvs, q, r;
    p_dz = 0; p_ov = 0; p_res = '0; steps = sz ? 16 : 8;
    case (op)
      2'b00: begin
        if (!sz) begin pl = longint'(d[7:0]) * longint'(s[7:0]); p_res = {16'h0, pl[15:0]}; p_tag = "R1"; end
        else begin pl = longint'(d[15:0]) * longint'(s[15:0]); p_res = pl[31:0]; p_tag = "R2"; end
      end
      2'b01: begin
        p_tag = "R3";
        if (!sz) begin pl = longint'($signed(d[7:0])) * longint'($signed(s[7:0])); p_res = {16'h0, pl[15:0]}; end
        else begin pl = longint'($signed(d[15:0])) * longint'($signed(s[15:0])); p_res = pl[31:0]; end
      end
      default: begin
        dvd = sz ? longint'(d) : longint'(d[15:0]);
        dvs = sz ? longint'(s) : longint'(s[7:0]);
        p_tag = sz ? "R5" : "R4";
        if (dvs == 0) begin p_dz = 1; p_res = d; steps = 0; p_tag = "R7"; end
        else begin
          q = dvd / dvs; r = dvd % dvs;
          if (q > (sz ? 65535 : 255)) begin p_ov = 1; steps = 0; p_tag = "R8"; end
          else if (sz) p_res = {r[15:0], q[15:0]};
          else p_res = {16'h0, r[7:0], q[7:0]};
        end
      end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    int lb;
    int n;
    if (!rst_n) begin
      left = 0; m_done = 0; held_res = '0; held_dz = 0; held_ov = 0; held_tag = "R11";
    end else begin
      lb = left;
      m_done = 0;
      if (left > 0) begin
        left--;
        if (left == 0) begin
          m_done = 1;
          held_res = p_res; held_dz = p_dz; held_ov = p_ov; held_tag = p_tag;
        end
      end
      if (lb == 0 && start_i && op_i != 2'b11) begin
        predict(op_i, size_i, dst_i, src_i, n);
        left = n + 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy_o == (left > 0), "R9 busy", {31'h0, busy_o}, {31'h0, left > 0});
      chk(done_o == m_done, "R6 done timing", {31'h0, done_o}, {31'h0, m_done});
      chk(divzero_o == held_dz, {held_tag, " R7 divzero"}, {31'h0, divzero_o}, {31'h0, held_dz});
      chk(ovf_o == held_ov, {held_tag, " R8 ovf"}, {31'h0, ovf_o}, {31'h0, held_ov});
      if (held_ov) begin
        if (m_done) held_res = result_o;
      end else begin
        chk(result_o == held_res, {held_tag, " R12 result"}, result_o, held_res);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic sz, input logic [31:0] d, input logic [15:0] s);
    @(negedge clk);
    start_i = 1'b1; op_i = op; size_i = sz; dst_i = d; src_i = s;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic settle();
    while (left > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic sz, input logic [31:0] d, input logic [15:0] s);
    issue(op, sz, d, s);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R6 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; size_i = 1'b0; dst_i = '0; src_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(!busy_o && !done_o, "R11 busy/done", {30'h0, busy_o, done_o}, 32'h0);
    chk(result_o == 32'h0, "R11 result", result_o, 32'h0);
    chk(!divzero_o && !ovf_o, "R11 flags", {30'h0, divzero_o, ovf_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(2'b00, 1'b0, 32'hFFFF_12FF, 16'h00FF);   // R1 255*255
    run_op(2'b00, 1'b0, 32'h0000_0003, 16'hAB05);   // R1 upper src bits unused
    run_op(2'b00, 1'b1, 32'h0000_FFFF, 16'hFFFF);   // R2
    run_op(2'b00, 1'b1, 32'h1234_0000, 16'h7FFF);   // R2 zero operand
    run_op(2'b01, 1'b0, 32'h0000_0080, 16'h0080);   // R3 -128*-128
    run_op(2'b01, 1'b0, 32'h0000_00FF, 16'h0001);   // R3 -1*1
    run_op(2'b01, 1'b1, 32'h0000_8000, 16'h8000);   // R3 word
    run_op(2'b01, 1'b1, 32'h0000_7FFF, 16'h8000);   // R3 word mixed sign
    run_op(2'b10, 1'b0, 32'h0000_03E8, 16'h0007);   // R4 1000/7
    run_op(2'b10, 1'b0, 32'h0000_06FF, 16'h0007);   // R4 upper just below divisor
    run_op(2'b10, 1'b1, 32'h0001_86A0, 16'd300);    // R5 100000/300
    run_op(2'b10, 1'b1, 32'hFFFE_FFFF, 16'hFFFF);   // R5 largest quotient
    run_op(2'b10, 1'b0, 32'hCAFE_0123, 16'hFF00);   // R7 byte zero divisor field
    chk(result_o == 32'hCAFE_0123 && divzero_o, "R7 dst returned", result_o, 32'hCAFE_0123);
    run_op(2'b10, 1'b1, 32'h0BAD_F00D, 16'h0000);   // R7 word
    run_op(2'b10, 1'b0, 32'h0000_0700, 16'h0007);   // R8 upper equals divisor
    chk(ovf_o && !divzero_o, "R8 overflow flag", {30'h0, divzero_o, ovf_o}, 32'h1);
    run_op(2'b10, 1'b1, 32'h0010_0000, 16'h0010);   // R8 word

    // R9: conflicting start in the middle of a run
    issue(2'b00, 1'b1, 32'h0000_1234, 16'h5678);
    repeat (3) @(negedge clk);
    issue(2'b10, 1'b0, 32'h0000_0000, 16'h0000);
    settle();
    chk(result_o == 32'h0626_0060 && !divzero_o, "R9 busy start ignored", result_o, 32'h0626_0060);

    // R10: no-op code
    issue(2'b11, 1'b1, 32'h1111_1111, 16'h2222);
    chk(!busy_o, "R10 no busy", {31'h0, busy_o}, 32'h0);
    repeat (20) @(negedge clk);
    chk(result_o == 32'h0626_0060, "R10 result kept", result_o, 32'h0626_0060);

    // back-to-back: start in the done cycle
    issue(2'b00, 1'b0, 32'h0000_0011, 16'h0011);
    while (!done_o) @(negedge clk);
    start_i = 1'b1; op_i = 2'b01; size_i = 1'b0; dst_i = 32'h0000_0085; src_i = 16'h0003;
    @(negedge clk);
    start_i = 1'b0;
    settle();

    for (int i = 0; i < 300; i++) begin
      logic [15:0] s;
      s = 16'($urandom);
      if (i % 3 == 0) s = 16'($urandom_range(0, 20));
      issue(2'($urandom_range(0, 3)), 1'($urandom), $urandom, s);
      if (i % 7 == 0) begin
        repeat (2) @(negedge clk);
        issue(2'($urandom_range(0, 2)), 1'($urandom), $urandom, 16'($urandom));
      end
      settle();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule